// File: doc/BRIEF.md
# Phase-Disposition Multicarrier Level Modulator

This block chooses, on every clock, which of thirteen output steps a multilevel inverter should apply, from -6 to +6. Twelve triangular carriers with the same height and timing are derived from one up/down counter. Each carrier sits in its own band: six bands stack upward from zero and six stack downward. An internally generated sine reference is compared against all twelve. The level is the signed number of bands that the reference has crossed.

The reference amplitude is the modulation index times six band heights. The index is an unsigned fraction of full scale. The reference is sampled once per carrier period from a quarter-wave sine table, which is addressed by a 32-bit phase accumulator. A two-bit select chooses the output frequency as 25, 50 or 100 Hz relative to a 3 kHz carrier. New index and frequency values are accepted only at a carrier-period boundary. The level output, a polarity flag and a carrier-period strobe feed the switch-state decoder that follows this block.

Top module: `pdpwm_modulator`

## Requirements
- R1: While reset is high, and on the clock after it is sampled high, level is 0, polarity is 0 and carrierStrobe is 1. Reset clears the phase accumulator and the latched index to 0, so every level in the first full carrier period after release is 0.
- R2: The carrier value c counts 0,1,…,B and then back down to 1, where B = 2^BAND_W − 1, so one carrier period is 2B clocks. carrierStrobe is high for exactly one clock per period: the clock in which the carrier is at 0.
- R3: In the positive half of the reference, the level registered at a clock is the number of k in 0..5 for which the reference magnitude is strictly greater than c + k·B. This uses the carrier value and the held state of the previous clock, so there is one clock of latency.
- R4: In the negative half of the reference, the level is minus the number of k in 0..5 for which the magnitude plus c is strictly greater than (k+1)·B. The same one-clock latency applies.
- R5: The level always lies in −6..+6. A positive level implies polarity 0, and a negative level implies polarity 1.
- R6: modIndex and freqSel are sampled only on the last clock of a carrier period (c = 1 on the way down). Changes at any other time have no effect until that clock.
- R7: freqSel encoding is 1 for 25 Hz, 2 for 100 Hz, and 0 or 3 for 50 Hz. The accumulator advances once per carrier period by floor(f·2^32 / 3000), and the peak level does not depend on the frequency chosen.
- R8: The reference magnitude is floor(s·idx·6B / 2^22). Here idx is the latched 10-bit index, and s is entry j of a 256-entry table holding round(4095·sin(π/2·(j+0.5)/256)). Phase bits [29:22] give j, inverted when bit 30 is set. Bit 31 selects the negative half and drives polarity.
- R9: The span of levels follows the index: idx = 150 (M ≤ 1/6) gives only −1..+1, idx = 600 (1/2 < M ≤ 2/3) peaks at ±4, and idx = 1023 peaks at ±6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| modIndex | input | IDX_W | Modulation index as a fraction of 2^IDX_W |
| freqSel | input | 2 | Output frequency select |
| level | output | LVL_W | Signed target level, −6..+6 |
| polarity | output | 1 | High while the reference is in its negative half |
| carrierStrobe | output | 1 | High on the first clock of each carrier period |

## Verification
The bench drives the index through values on either side of the band thresholds. A wrong band offset or a `>=` in place of `>` would shift the peak level, or would produce levels at the equality points where none should appear. It changes the index in the middle of a carrier period. A design that samples the index continuously would then change its levels before the boundary, when they should stay on the old index. It switches between 25 and 100 Hz and measures the length of each half cycle in carrier periods. A wrong step or swapped select code would show up as the wrong half-cycle length or as a different peak. Applying reset in the middle of a run would expose a phase accumulator or latched index that survives reset, because nonzero levels would appear in the first period after release.

// File: rtl/pdpwm_pkg.sv
package pdpwm_pkg;

  typedef struct packed {
    logic wrap;   // last clock of the carrier period
    logic start;  // first clock of the carrier period
  } carrierCtl_t;

  function automatic logic [31:0] stepFor(input logic [1:0] sel, input int carrierHz);
    longint f;
    case (sel)
      2'd1:    f = 25;
      2'd2:    f = 100;
      default: f = 50;
    endcase
    return 32'((f <<< 32) / longint'(carrierHz));
  endfunction

endpackage

// File: rtl/pdpwm_carrier.sv
module pdpwm_carrier #(
  parameter int BAND_W = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  output pdpwm_pkg::carrierCtl_t     ctl,
  output logic [BAND_W:0]            carrierVal
);
  localparam int BAND   = 2 ** BAND_W - 1;
  localparam int PERIOD = 2 * BAND;
  localparam int CNT_W  = BAND_W + 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                              cnt <= '0;
    else if (cnt == CNT_W'(PERIOD - 1))   cnt <= '0;
    else                                  cnt <= cnt + 1'b1;
  end

  assign carrierVal = (cnt < CNT_W'(BAND)) ? cnt : CNT_W'(PERIOD) - cnt;
  assign ctl.wrap   = (cnt == CNT_W'(PERIOD - 1));
  assign ctl.start  = (cnt == '0);
endmodule

// File: rtl/pdpwm_sine_rom.sv
module pdpwm_sine_rom #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int  DEPTH   = 2 ** AW;
  localparam real HALF_PI = 1.5707963267948966;

  function automatic int sineEntry(input int j);
    real a;
    a = HALF_PI * (real'(j) + 0.5) / real'(DEPTH);
    return $rtoi(real'(2 ** DW - 1) * $sin(a) + 0.5);
  endfunction

  logic [DW-1:0] romData [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    localparam int VAL = sineEntry(g);
    assign romData[g] = DW'(VAL);
  end

  assign data = romData[addr];
endmodule

// File: rtl/pdpwm_level_path.sv
module pdpwm_level_path #(
  parameter int BAND_W     = 10,
  parameter int IDX_W      = 10,
  parameter int SIN_W      = 12,
  parameter int LUT_AW     = 8,
  parameter int HALF       = 6,
  parameter int CARRIER_HZ = 3000,
  parameter int LVL_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pdpwm_pkg::carrierCtl_t  ctl,
  input  logic [BAND_W:0]         carrierVal,
  input  logic [IDX_W-1:0]        modIndex,
  input  logic [1:0]              freqSel,
  output logic [LVL_W-1:0]        levelCode,
  output logic                    negHalf
);
  localparam int BAND   = 2 ** BAND_W - 1;
  localparam int FULL   = HALF * BAND;
  localparam int FULL_W = $clog2(FULL + 1);
  localparam int SCL_W  = SIN_W + IDX_W;
  localparam int PROD_W = SCL_W + FULL_W;
  localparam int REF_W  = $clog2((HALF + 1) * BAND + 1);
  localparam logic [31:0] STEP_SLOW = pdpwm_pkg::stepFor(2'd1, CARRIER_HZ);
  localparam logic [31:0] STEP_MID  = pdpwm_pkg::stepFor(2'd0, CARRIER_HZ);
  localparam logic [31:0] STEP_FAST = pdpwm_pkg::stepFor(2'd2, CARRIER_HZ);

  logic [31:0]       phaseAcc;
  logic [IDX_W-1:0]  idxReg;
  logic [31:0]       stepSel;

  always_comb begin
    case (freqSel)
      2'd1:    stepSel = STEP_SLOW;
      2'd2:    stepSel = STEP_FAST;
      default: stepSel = STEP_MID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      idxReg   <= '0;
    end else if (ctl.wrap) begin
      phaseAcc <= phaseAcc + stepSel;
      idxReg   <= modIndex;
    end
  end

  // quarter-wave folding
  logic [LUT_AW-1:0] romAddr;
  logic [SIN_W-1:0]  sinMag;
  assign romAddr = phaseAcc[30] ? ~phaseAcc[29 -: LUT_AW] : phaseAcc[29 -: LUT_AW];

  pdpwm_sine_rom #(.AW(LUT_AW), .DW(SIN_W)) uRom (.addr(romAddr), .data(sinMag));

  // scale to six bands
  logic [SCL_W-1:0]  scaled;
  logic [PROD_W-1:0] prod;
  logic [FULL_W-1:0] refMag;
  assign scaled = SCL_W'(sinMag) * SCL_W'(idxReg);
  assign prod   = PROD_W'(scaled) * PROD_W'(FULL);
  assign refMag = prod[PROD_W-1:SCL_W];

  // band comparisons
  logic [HALF-1:0] hiHit, loHit;
  for (genvar k = 0; k < HALF; k++) begin : gBand
    assign hiHit[k] = REF_W'(refMag) > (REF_W'(carrierVal) + REF_W'(k * BAND));
    assign loHit[k] = (REF_W'(refMag) + REF_W'(carrierVal)) > REF_W'((k + 1) * BAND);
  end

  logic [LVL_W-1:0] hiCnt, loCnt, levelNext;
  assign hiCnt     = LVL_W'($countones(hiHit));
  assign loCnt     = LVL_W'($countones(loHit));
  assign levelNext = phaseAcc[31] ? (LVL_W'(0) - loCnt) : hiCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      levelCode <= '0;
      negHalf   <= 1'b0;
    end else begin
      levelCode <= levelNext;
      negHalf   <= phaseAcc[31];
    end
  end
endmodule

// File: rtl/pdpwm_modulator.sv
module pdpwm_modulator #(
  parameter int BAND_W     = 10,
  parameter int IDX_W      = 10,
  parameter int SIN_W      = 12,
  parameter int LUT_AW     = 8,
  parameter int HALF       = 6,
  parameter int CARRIER_HZ = 3000,
  localparam int LVL_W     = $clog2(HALF + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [IDX_W-1:0]         modIndex,
  input  logic [1:0]               freqSel,
  output logic signed [LVL_W-1:0]  level,
  output logic                     polarity,
  output logic                     carrierStrobe
);
  pdpwm_pkg::carrierCtl_t ctrlBus;
  logic [BAND_W:0]        carrierVal;
  logic [LVL_W-1:0]       levelCode;

  pdpwm_carrier #(.BAND_W(BAND_W)) uCar (
    .clk(clk), .rst(rst), .ctl(ctrlBus), .carrierVal(carrierVal)
  );

  pdpwm_level_path #(
    .BAND_W(BAND_W), .IDX_W(IDX_W), .SIN_W(SIN_W), .LUT_AW(LUT_AW),
    .HALF(HALF), .CARRIER_HZ(CARRIER_HZ), .LVL_W(LVL_W)
  ) uDp (
    .clk(clk), .rst(rst), .ctl(ctrlBus), .carrierVal(carrierVal),
    .modIndex(modIndex), .freqSel(freqSel),
    .levelCode(levelCode), .negHalf(polarity)
  );

  assign level         = levelCode;
  assign carrierStrobe = ctrlBus.start;
endmodule

// File: rtl/pdpwm_checks.sv
module pdpwm_checks #(
  parameter int IDX_W = 10,
  parameter int HALF  = 6,
  parameter int LVL_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic signed [LVL_W-1:0] level,
  input logic                    polarity,
  input logic                    carrierStrobe,
  input logic                    wrap,
  input logic [IDX_W-1:0]        idxHeld,
  input logic [31:0]             phaseHeld
);
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  // R1: outputs at their reset values after a reset edge
  always @(negedge clk) begin
    if (rstSeen === 1'b1)
      a_reset_state_r1: assert (level == 0 && !polarity && carrierStrobe);
  end

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    carrierStrobe |=> !carrierStrobe);

  p_level_range_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(level) <= HALF) && (int'(level) >= -HALF));

  p_pos_polarity_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(level) > 0) |-> !polarity);

  p_neg_polarity_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(level) < 0) |-> polarity);

  p_index_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(idxHeld));

  p_phase_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(phaseHeld));

  p_zero_index_r9: assert property (@(posedge clk) disable iff (rst)
    (idxHeld == '0) |=> (level == 0));
endmodule

bind pdpwm_modulator pdpwm_checks #(.IDX_W(IDX_W), .HALF(HALF), .LVL_W(LVL_W)) uChk (
  .clk(clk), .rst(rst), .level(level), .polarity(polarity),
  .carrierStrobe(carrierStrobe), .wrap(ctrlBus.wrap),
  .idxHeld(uDp.idxReg), .phaseHeld(uDp.phaseAcc)
);

// File: tb/sim_pdpwm_modulator.sv
`timescale 1ns/1ps
module sim_pdpwm_modulator;
  localparam int BW = 5;
  localparam int B  = 2 ** BW - 1;
  localparam int P  = 2 * B;
  localparam real HALF_PI = 1.5707963267948966;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [9:0]        modIndex = '0;
  logic [1:0]        freqSel  = '0;
  logic signed [3:0] level;
  logic              polarity;
  logic              carrierStrobe;

  always #4 clk = ~clk;   // 125 MHz

  pdpwm_modulator #(.BAND_W(BW)) u0 (
    .clk(clk), .rst(rst), .modIndex(modIndex), .freqSel(freqSel),
    .level(level), .polarity(polarity), .carrierStrobe(carrierStrobe)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          sineTab [256];
  int          mCnt   = 0;
  logic [31:0] mPhase = '0;
  int          mIdx   = 0;
  int          expLevel = 0;
  bit          expPol   = 0;
  bit          expStrobe = 1;
  bit          modelOn  = 0;

  function automatic longint stepOf(input logic [1:0] s);
    longint f = (s == 2'd1) ? 25 : (s == 2'd2) ? 100 : 50;
    return (f <<< 32) / 3000;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mPhase = '0; mIdx = 0; expLevel = 0; expPol = 0;
    end else begin
      int tv, j, lv;
      longint mag;
      tv = (mCnt < B) ? mCnt : P - mCnt;
      j  = int'(mPhase[29:22]);
      if (mPhase[30]) j = 255 - j;
      mag = (longint'(sineTab[j]) * mIdx * 6 * B) >>> 22;
      lv = 0;
      for (int k = 0; k < 6; k++) begin
        if (!mPhase[31]) begin
          if (mag > tv + k * B) lv++;
        end else begin
          if (mag + tv > (k + 1) * B) lv--;
        end
      end
      expLevel = lv;
      expPol   = mPhase[31];
      if (mCnt == P - 1) begin
        mPhase = 32'(longint'(mPhase) + stepOf(freqSel));
        mIdx   = int'(modIndex);
        mCnt   = 0;
      end else begin
        mCnt++;
      end
    end
    expStrobe = (mCnt == 0);
  end

  // ---------------- per-clock comparison and tracking ----------------
  int maxL = 0, minL = 0;
  bit prevPol = 0;
  int runLen = 0, lastHighRun = 0;

  always @(negedge clk) begin
    if (modelOn) begin
      check(int'(level) == expLevel,
            (expLevel > 0) ? "R3" : (expLevel < 0) ? "R4" : (expPol ? "R4" : "R3"),
            "level", int'(level), expLevel);
      check(polarity == expPol, "R8", "polarity", polarity, expPol);
      check(carrierStrobe == expStrobe, "R2", "strobe", carrierStrobe, expStrobe);
    end
    if (int'(level) > maxL) maxL = int'(level);
    if (int'(level) < minL) minL = int'(level);
    if (polarity != prevPol) begin
      if (prevPol) lastHighRun = runLen;
      runLen = 1;
    end else begin
      runLen++;
    end
    prevPol = polarity;
  end

  task automatic clearTrack();
    maxL = 0; minL = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!carrierStrobe);
  endtask

  task automatic zeroPeriod(input string req, input string what);
    int nz = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (level != 0) nz++;
    end
    check(nz == 0, req, what, nz, 0);
  endtask

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int j = 0; j < 256; j++)
      sineTab[j] = $rtoi(4095.0 * $sin(HALF_PI * (real'(j) + 0.5) / 256.0) + 0.5);

    cyc(2);
    modelOn = 1;
    cyc(3);
    // R1: reset state
    check(level == 0, "R1", "reset level", level, 0);
    check(polarity == 0, "R1", "reset polarity", polarity, 0);
    check(carrierStrobe == 1, "R1", "reset strobe", carrierStrobe, 1);

    modIndex = 10'd1023; freqSel = 2'd0; rst = 0;
    zeroPeriod("R1", "nonzero levels in first period");

    // R9: full index reaches +-6
    cyc(P); clearTrack(); cyc(61 * P);
    check(maxL == 6, "R9", "peak at idx 1023", maxL, 6);
    check(minL == -6, "R9", "trough at idx 1023", minL, -6);

    // R9: small index stays within one band
    modIndex = 10'd150;
    cyc(2 * P); clearTrack(); cyc(61 * P);
    check(maxL == 1, "R9", "peak at idx 150", maxL, 1);
    check(minL == -1, "R9", "trough at idx 150", minL, -1);

    // R9: mid index peaks at four bands
    modIndex = 10'd600;
    cyc(2 * P); clearTrack(); cyc(61 * P);
    check(maxL == 4, "R9", "peak at idx 600", maxL, 4);
    check(minL == -4, "R9", "trough at idx 600", minL, -4);

    // R7: 100 Hz half cycle and amplitude
    modIndex = 10'd1023; freqSel = 2'd2;
    cyc(40 * P); clearTrack(); lastHighRun = 0; cyc(70 * P);
    check(lastHighRun >= 14 * P && lastHighRun <= 16 * P, "R7", "half cycle at 100 Hz",
          lastHighRun, 15 * P);
    check(maxL == 6, "R7", "peak at 100 Hz", maxL, 6);

    // R7: 25 Hz half cycle and amplitude
    freqSel = 2'd1;
    cyc(130 * P); clearTrack(); lastHighRun = 0; cyc(250 * P);
    check(lastHighRun >= 59 * P && lastHighRun <= 61 * P, "R7", "half cycle at 25 Hz",
          lastHighRun, 60 * P);
    check(maxL == 6, "R7", "peak at 25 Hz", maxL, 6);

    // R6: mid-period index change held until the boundary
    freqSel = 2'd0;
    cyc(3 * P);
    waitStrobe(); cyc(5);
    modIndex = 10'd0;
    freqSel  = 2'd3;
    begin
      int nzDut = 0, nzExp = 0;
      for (int i = 0; i < P - 10; i++) begin
        @(negedge clk);
        if (level != 0) nzDut++;
        if (expLevel != 0) nzExp++;
      end
      check(nzDut == nzExp, "R6", "levels before boundary use old index", nzDut, nzExp);
    end
    waitStrobe();
    zeroPeriod("R6", "nonzero levels after index 0 latched");

    // R1: reset in the middle of a run
    modIndex = 10'd1023;
    cyc(5 * P + 7);
    rst = 1;
    cyc(3);
    check(level == 0, "R1", "mid-run reset level", level, 0);
    check(polarity == 0, "R1", "mid-run reset polarity", polarity, 0);
    check(carrierStrobe == 1, "R1", "mid-run reset strobe", carrierStrobe, 1);
    rst = 0;
    zeroPeriod("R1", "nonzero levels after mid-run reset");
    cyc(4 * P);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule